// File: doc/BRIEF.md
# Two-Wire EEPROM Access Host Controller

This block is the host side of a serial link to a configuration memory that has one clock line and one bidirectional data line. A request carries a 4-bit command code, a 3-bit register address and 32 bits of write data. The controller turns each accepted request into a framed transaction. It drives the clock at a rate set by a parameter. It shifts out a start bit, the command and the address, and then either sends 32 payload bits or, for a read, releases the data line and collects 32 bits from the device.

Every frame closes with one extra clock pulse during which the data line is held low. The controller then stays unavailable for a parameterised number of system clocks, so that the device gets the long quiet time it needs after each access. The remote side samples the data line on the falling clock edge. For that reason the controller changes its data output only together with the rising edge and holds it for the whole high half of each pulse. The reserved command code is refused at the request port and produces no line activity.

Top module: `two_wire_eeprom_host`

## Requirements
- R1: During and right after a synchronous active-low reset, `req_ready`=1, `sclk`=0, `sdat_oe`=1, `sdat_out`=0, `rd_valid`=0 and `cmd_err`=0. This also holds when reset is applied in the middle of a frame.
- R2: Every frame begins with eight clock pulses carrying a start bit of value 1, then the four command bits with the most significant bit first, then the three address bits with the most significant bit first. `sdat_out` and `sdat_oe` change only when `sclk` rises and stay constant while `sclk` is high.
- R3: A command whose two upper bits are not both 1 (codes 0000 to 1011) is a write-type frame. After the header it sends the 32 data bits with the most significant bit first, for 41 pulses in total including the trailing pulse.
- R4: Command 1100 is a read. After the header, `sdat_oe` is 0 for one turnaround pulse and for 32 capture pulses. `sdat_in` is sampled at the end of each capture pulse's high half, and the bits are assembled most significant bit first. The frame has 42 pulses.
- R5: `rd_valid` is a single-cycle pulse, asserted in the cycle after the 32nd read bit is sampled, with `rd_data` holding the assembled word. It never asserts for non-read frames.
- R6: Commands 1110 and 1111 send only the header and the trailing pulse, for 9 pulses.
- R7: Command 1101 is refused. `cmd_err` pulses for one cycle after the request, no `sclk` edge follows, and `req_ready` stays 1.
- R8: The last pulse of every frame has `sdat_out`=0 with `sdat_oe`=1.
- R9: The high half and the low half of each `sclk` pulse each last `CLK_DIV` system clocks.
- R10: `req_ready` is 0 from the cycle after acceptance through the frame and for `GAP_CYCLES` further cycles after the trailing pulse ends. Requests presented while `req_ready` is 0 are ignored, and `sclk` stays 0 while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 4 | Command code |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Payload for write-type commands |
| req_ready | output | 1 | Controller idle and quiet time elapsed |
| cmd_err | output | 1 | One-cycle pulse when the reserved code is refused |
| rd_valid | output | 1 | One-cycle pulse with a completed read word |
| rd_data | output | 32 | Read word, most significant bit received first |
| sclk | output | 1 | Serial clock to the device |
| sdat_out | output | 1 | Serial data driven by the host |
| sdat_oe | output | 1 | Host drives the data line when 1 |
| sdat_in | input | 1 | Serial data line as seen by the host |

## Verification
The bench builds the controller with `CLK_DIV`=2 and `GAP_CYCLES`=20. With these values a 42-pulse read takes 168 system clocks, and the quiet period is short enough to count exactly on every transaction. The shipped defaults of 50 and 2,000,000 would make a single quiet period 2 million cycles long, so the whole ready-low window can only be measured to the cycle with the smaller values. The short divider also places the device model's data change, made after the rising edge, one system clock ahead of the host's sampling point, which exercises the release and capture windows.

// File: rtl/twm_pkg.sv
// Shared types and constants for the two-wire EEPROM host.
// Assumes the frame layout: start bit, command, address, payload.
package twm_pkg;

    localparam int CMD_W  = 4;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int HDR_W  = 1 + CMD_W + ADDR_W;

    localparam logic [CMD_W-1:0] CMD_READ     = 4'b1100;
    localparam logic [CMD_W-1:0] CMD_RESERVED = 4'b1101;

    // Sequencer phase: idle, clock high half, clock low half.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } twm_phase_e;

    // Shape of the frame chosen from the command code.
    typedef enum logic [1:0] {
        FR_WRITE  = 2'd0,
        FR_READ   = 2'd1,
        FR_HEADER = 2'd2
    } twm_frame_e;

    // Map a command code to its frame shape (reserved code is filtered earlier).
    function automatic twm_frame_e frame_of(input logic [CMD_W-1:0] c);
        if (c == CMD_READ)       return FR_READ;
        else if (c[3:2] == 2'b11) return FR_HEADER;
        else                      return FR_WRITE;
    endfunction

endpackage

// File: rtl/twm_divider.sv
// Half-period timer: while run is high, tick pulses once every DIV cycles.
// Assumes DIV >= 1; the count restarts whenever run is low.
module twm_divider #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/twm_gap.sv
// Post-frame quiet timer: load starts a down-count of GAP cycles;
// quiet is high once the count has reached zero. Assumes GAP >= 1.
module twm_gap #(
    parameter int GAP = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic quiet
);
    localparam int GW = $clog2(GAP + 1);

    logic [GW-1:0] left_q;

    assign quiet = (left_q == '0);

    // Load on frame end, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (load)   left_q <= GW'(GAP);
        else if (!quiet) left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/twm_seq.sv
// Frame sequencer: walks clock pulses (slots) of one transaction, shifts
// the header and payload out MSB first, releases the line for reads and
// shifts the returned word in. Assumes start is only asserted while idle.
module twm_seq
    import twm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              sdi,
    output logic              busy,
    output logic              frame_done,
    output logic              sclk,
    output logic              sdo,
    output logic              oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TX_W    = HDR_W + DATA_W;
    localparam int LAST_WR = HDR_W + DATA_W;
    localparam int LAST_RD = HDR_W + DATA_W + 1;
    localparam int LAST_HO = HDR_W;
    localparam int CAP_LO  = HDR_W + 1;
    localparam int CAP_HI  = HDR_W + DATA_W;
    localparam int SLOT_W  = $clog2(LAST_RD + 1);

    twm_phase_e        phase_q;
    twm_frame_e        frame_q;
    logic [SLOT_W-1:0] slot_q;
    logic [TX_W-1:0]   tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              rdv_q;
    logic [SLOT_W-1:0] last_slot;
    logic              released;
    logic              capture;
    logic              trailing;

    // Select the final slot index of the current frame shape.
    always_comb begin
        unique case (frame_q)
            FR_READ:   last_slot = SLOT_W'(LAST_RD);
            FR_HEADER: last_slot = SLOT_W'(LAST_HO);
            default:   last_slot = SLOT_W'(LAST_WR);
        endcase
    end

    // Decode the role of the current slot.
    always_comb begin
        released = (phase_q != PH_IDLE) && (frame_q == FR_READ)
                   && (slot_q >= SLOT_W'(HDR_W)) && (slot_q <= SLOT_W'(CAP_HI));
        capture  = (frame_q == FR_READ)
                   && (slot_q >= SLOT_W'(CAP_LO)) && (slot_q <= SLOT_W'(CAP_HI));
        trailing = (slot_q == last_slot);
    end

    // Advance phases and slots, shift transmit and receive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            frame_q <= FR_WRITE;
            slot_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            rdv_q   <= 1'b0;
        end else begin
            rdv_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_HIGH;
                        frame_q <= frame_of(cmd);
                        slot_q  <= '0;
                        tx_q    <= {1'b1, cmd, addr, wdata};
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        phase_q <= PH_LOW;
                        if (capture) begin
                            rx_q <= {rx_q[DATA_W-2:0], sdi};
                            if (slot_q == SLOT_W'(CAP_HI)) rdv_q <= 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (trailing) begin
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_HIGH;
                            slot_q  <= slot_q + 1'b1;
                            tx_q    <= {tx_q[TX_W-2:0], 1'b0};
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy       = (phase_q != PH_IDLE);
    assign frame_done = (phase_q == PH_LOW) && tick && trailing;
    assign sclk       = (phase_q == PH_HIGH);
    assign oe         = !released;
    assign sdo        = busy && !released && !trailing && tx_q[TX_W-1];
    assign rd_valid   = rdv_q;
    assign rd_data    = rx_q;
endmodule

// File: rtl/two_wire_eeprom_host.sv
// Top of the two-wire EEPROM host. Accepts one request when ready,
// refuses the reserved code, runs a frame and then holds ready low for
// the quiet time. Assumes CLK_DIV >= 1 and GAP_CYCLES >= 1.
module two_wire_eeprom_host
    import twm_pkg::*;
#(
    parameter int CLK_DIV    = 50,
    parameter int GAP_CYCLES = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              cmd_err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              sdat_out,
    output logic              sdat_oe,
    input  logic              sdat_in
);
    logic busy;
    logic quiet;
    logic tick;
    logic frame_done;
    logic take;
    logic start;
    logic err_q;

    assign req_ready = !busy && quiet;
    assign take      = req_valid && req_ready;
    assign start     = take && (req_cmd != CMD_RESERVED);

    // Flag a refused reserved command for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= take && (req_cmd == CMD_RESERVED);
    end
    assign cmd_err = err_q;

    twm_divider #(.DIV(CLK_DIV)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    twm_gap #(.GAP(GAP_CYCLES)) i_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_done),
        .quiet (quiet)
    );

    twm_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (req_cmd),
        .addr       (req_addr),
        .wdata      (req_wdata),
        .tick       (tick),
        .sdi        (sdat_in),
        .busy       (busy),
        .frame_done (frame_done),
        .sclk       (sclk),
        .sdo        (sdat_out),
        .oe         (sdat_oe),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/twm_checker.sv
// Protocol checker for the two-wire EEPROM host, bound to the top.
// Measures the clock high half with its own counter.
module twm_checker #(
    parameter int CLK_DIV = 50
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic cmd_err,
    input logic rd_valid,
    input logic sclk,
    input logic sdat_out,
    input logic sdat_oe
);
    logic [31:0] hi_cnt;

    // Count consecutive cycles with the serial clock high.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk) hi_cnt <= '0;
        else                 hi_cnt <= hi_cnt + 1;
    end

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> ($stable(sdat_out) && $stable(sdat_oe)));

    assert_released_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !sdat_oe);

    assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_refuse_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!sclk && req_ready));

    assert_high_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == 32'(CLK_DIV)));

    assert_quiet_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sclk && sdat_oe && !sdat_out));
endmodule

bind two_wire_eeprom_host twm_checker #(.CLK_DIV(CLK_DIV)) i_twm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_err   (cmd_err),
    .rd_valid  (rd_valid),
    .sclk      (sclk),
    .sdat_out  (sdat_out),
    .sdat_oe   (sdat_oe)
);

// File: tb/test_two_wire_eeprom_host.sv
module test_two_wire_eeprom_host;
    localparam int D = 2;
    localparam int G = 20;
    localparam int NV = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, cmd_err, rd_valid, sclk, sdat_out, sdat_oe;
    logic [31:0] rd_data;
    logic        sdat_in = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    two_wire_eeprom_host #(.CLK_DIV(D), .GAP_CYCLES(G)) i_two_wire_eeprom_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cmd_err(cmd_err), .rd_valid(rd_valid), .rd_data(rd_data), .sclk(sclk),
        .sdat_out(sdat_out), .sdat_oe(sdat_oe), .sdat_in(sdat_in)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL R10 watchdog expired: actual=%0d expected<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Vector: {cmd[3:0], addr[2:0], wdata[31:0], device read word[31:0]}
    localparam logic [70:0] VEC [NV] = '{
        {4'b0110, 3'd5, 32'hA5A5_0F0F, 32'h0},
        {4'b0100, 3'd0, 32'hFFFF_FFFF, 32'h0},
        {4'b1100, 3'd7, 32'h1234_5678, 32'h8000_0001},
        {4'b1100, 3'd2, 32'h0,         32'hDEAD_BEEF},
        {4'b1110, 3'd3, 32'hFFFF_FFFF, 32'h0},
        {4'b1111, 3'd1, 32'h0,         32'h0},
        {4'b1000, 3'd4, 32'h0000_0001, 32'h0}
    };

    // Run one transaction and compare the line activity against the requirements.
    task automatic run_txn(input logic [3:0] c, input logic [2:0] a,
                           input logic [31:0] wd, input logic [31:0] rp,
                           input bit spam);
        int kind;                  // 0 write, 1 read, 2 header only
        int nslots;
        logic [7:0] hdr;
        logic got_bit [42];
        logic got_oe  [42];
        int rises = 0, falls = 0, busy = 0, nrdv = 0, guard = 0;
        logic prev = 1'b0;
        logic [31:0] rword = '0;
        bit bits_ok = 1'b1, oe_ok = 1'b1, trail_ok;
        hdr = {1'b1, c, a};
        kind = (c == 4'b1100) ? 1 : (c[3:2] == 2'b11) ? 2 : 0;
        nslots = (kind == 1) ? 42 : (kind == 2) ? 9 : 41;
        for (int k = 0; k < 42; k++) begin got_bit[k] = 1'b0; got_oe[k] = 1'b1; end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = wd;
        @(negedge clk);
        if (spam) begin
            req_cmd = 4'b1110; req_addr = 3'd6; req_wdata = 32'h5555_5555;
        end else begin
            req_valid = 1'b0;
        end
        while (!req_ready && guard < 20000) begin
            guard++;
            busy++;
            if (sclk && !prev) begin
                if (kind == 1 && rises >= 9 && rises <= 40) sdat_in = rp[40 - rises];
                else sdat_in = 1'b1;
                rises++;
            end
            if (!sclk && prev) begin
                if (falls < 42) begin got_bit[falls] = sdat_out; got_oe[falls] = sdat_oe; end
                falls++;
            end
            if (rd_valid) begin nrdv++; rword = rd_data; end
            prev = sclk;
            if (spam && falls >= nslots) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        sdat_in = 1'b0;
        // Expected bit stream per slot.
        for (int k = 0; k < nslots - 1 && k < 42; k++) begin
            if (k < 8) begin
                if (got_bit[k] !== hdr[7 - k] || got_oe[k] !== 1'b1) bits_ok = 1'b0;
            end else if (kind == 0) begin
                if (got_bit[k] !== wd[39 - k] || got_oe[k] !== 1'b1) bits_ok = 1'b0;
            end else if (kind == 1) begin
                if (got_oe[k] !== 1'b0) oe_ok = 1'b0;
            end
        end
        trail_ok = (got_bit[nslots - 1] === 1'b0) && (got_oe[nslots - 1] === 1'b1);
        chk(bits_ok, (kind == 0) ? "R3" : "R2", "header/payload bits", {60'h0, c}, {60'h0, c});
        chk(falls == nslots, (kind == 1) ? "R4" : (kind == 2) ? "R6" : "R3",
            "pulse count", 64'(falls), 64'(nslots));
        chk(trail_ok, "R8", "trailing pulse low and driven",
            {62'h0, got_bit[nslots - 1], got_oe[nslots - 1]}, 64'h1);
        chk(busy == nslots * 2 * D + G, spam ? "R10 ignored-request" : "R10 quiet-time",
            "ready low cycles", 64'(busy), 64'(nslots * 2 * D + G));
        if (kind == 1) begin
            chk(oe_ok, "R4", "line released for turnaround and capture", 64'(oe_ok), 64'h1);
            chk(nrdv == 1, "R5", "read valid pulses", 64'(nrdv), 64'h1);
            chk(rword == rp, "R4", "read word", {32'h0, rword}, {32'h0, rp});
        end else begin
            chk(nrdv == 0, "R5", "no read valid on non-read", 64'(nrdv), 64'h0);
        end
    endtask

    initial begin
        int quiet_ok;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(req_ready && !sclk && sdat_oe && !sdat_out && !rd_valid && !cmd_err,
            "R1", "reset outputs",
            {58'h0, req_ready, sclk, sdat_oe, sdat_out, rd_valid, cmd_err}, 64'h28);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            run_txn(VEC[i][70:67], VEC[i][66:64], VEC[i][63:32], VEC[i][31:0], 1'b0);

        // R10: requests held while busy are ignored
        run_txn(4'b0111, 3'd6, 32'hC3C3_3C3C, 32'h0, 1'b1);

        // R7: reserved code refused without clocking
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = 4'b1101; req_addr = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_err === 1'b1, "R7", "error flag raised", 64'(cmd_err), 64'h1);
        chk(req_ready === 1'b1, "R7", "ready stays high", 64'(req_ready), 64'h1);
        @(negedge clk);
        chk(cmd_err === 1'b0, "R7", "error flag single cycle", 64'(cmd_err), 64'h0);
        quiet_ok = 1;
        for (int k = 0; k < 10; k++) begin
            if (sclk !== 1'b0) quiet_ok = 0;
            @(negedge clk);
        end
        chk(quiet_ok == 1, "R7", "no clock after refusal", 64'(quiet_ok), 64'h1);

        // R1: reset in the middle of a frame
        req_valid = 1'b1; req_cmd = 4'b1100; req_addr = 3'd1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !sclk && sdat_oe && !sdat_out && !rd_valid && !cmd_err,
            "R1", "mid-frame reset outputs",
            {58'h0, req_ready, sclk, sdat_oe, sdat_out, rd_valid, cmd_err}, 64'h28);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: a fresh frame runs normally after the reset
        run_txn(4'b0101, 3'd3, 32'h8000_0000, 32'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule